// File: doc/BRIEF.md
# Cross-Domain Peripheral Register Synchronizer

This block is the register front end of a peripheral whose bus clock and core clock have no fixed phase relation. A simple APB-style bus, clocked by the bus clock, reads and writes a small register set. Some registers live entirely in the bus domain and answer in one cycle. Others hold core-domain state: the control word, the output data word and the data buffer. Writes to these registers are carried into the core clock domain, and reads of the core data word are carried back from it.

A write to a synchronized register is accepted at once. It is latched into a holding register, and a toggle request crosses to the core side through a two-flop synchronizer. The core applies the write and returns a toggle acknowledge through a second synchronizer. A busy status bit covers the whole exchange. When the exchange ends, a ready flag is set, and that flag can raise an interrupt. A second synchronized access that arrives while busy is high is held with wait states and then completes normally. The core side also turns the enable bit, the run-in-standby bit and a standby input into an output-enable result.

Top module: `regsync_top`

## Requirements
- R1: A write to CTRL (address 0), DATA (address 4) or DATABUF (address 5) changes the core outputs `coreEnable`, `coreData` or `coreDataBuf` only through the handshake. When busy is low, the write completes with no wait state, and the new value is on the core output within 40 bus cycles.
- R2: A read of DATA (address 4) holds `pready` low until the core's current data word has been carried back. It then returns that word on `prdata`.
- R3: STATUS (address 3) bit 0 is the busy flag. It reads 1 from the bus cycle after a synchronized access is accepted, and it returns to 0 once the acknowledge is back.
- R4: A synchronized access that arrives while busy is 1 gets at least one wait state. It is not dropped, and its value takes effect after the earlier operation.
- R5: INTFLAG (address 2) bit 0 is set when a synchronized operation completes. Writing 1 to that bit clears it.
- R6: `irq` equals INTFLAG bit 0 AND INTEN (address 1) bit 0.
- R7: Reads and writes of INTEN, INTFLAG and STATUS complete with no wait states, even while busy is 1.
- R8: CTRL bit 1 is enable and CTRL bit 2 is run-in-standby. `outEnable` is enable AND (NOT `coreStandby` OR run-in-standby).
- R9: Writing CTRL with bit 0 (software reset) set clears `coreData`, `coreDataBuf`, enable and run-in-standby in the core domain. After that write, CTRL reads back 0.
- R10: After reset, busy, INTFLAG, INTEN, `irq`, `coreData`, `coreDataBuf` and `outEnable` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Bus-domain reset, active low |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 3 | Register word address |
| pwdata | input | DW (16) | Write data |
| prdata | output | DW (16) | Read data |
| pready | output | 1 | Transfer completes when high |
| irq | output | 1 | Synchronization-ready interrupt |
| cclk | input | 1 | Core clock |
| cresetn | input | 1 | Core-domain reset, active low |
| coreStandby | input | 1 | Core-side standby indication |
| coreData | output | DW (16) | Core-domain data word |
| coreDataBuf | output | DW (16) | Core-domain data buffer |
| coreEnable | output | 1 | Core-domain enable |
| outEnable | output | 1 | Output enable after standby gating |

## Verification
A write to a synchronized register returns `pready` in its first access cycle. Busy is already visible to a status read issued right after that write. The core outputs, the falling edge of busy and the set flag appear a few core cycles plus two bus cycles later, so the bench waits a fixed 40 bus cycles before comparing them. The bench counts wait states in the access phase by sampling `pready` on the falling bus-clock edge. An unsynchronized access must show a count of zero, a colliding or DATA-read access must show a count above zero, and read data is taken on the same edge on which `pready` is seen high.

// File: rtl/regsync_pkg.sv
package regsync_pkg;
  typedef enum logic [1:0] {OP_CTRL, OP_DATA, OP_BUF, OP_READ} opKind_e;

  typedef struct packed {
    logic    launch;
    opKind_e kind;
  } syncStrobe_t;

  localparam logic [2:0] ADDR_CTRL   = 3'd0;
  localparam logic [2:0] ADDR_INTEN  = 3'd1;
  localparam logic [2:0] ADDR_FLAG   = 3'd2;
  localparam logic [2:0] ADDR_STATUS = 3'd3;
  localparam logic [2:0] ADDR_DATA   = 3'd4;
  localparam logic [2:0] ADDR_BUF    = 3'd5;

  localparam int CTRL_SWRST = 0;
  localparam int CTRL_EN    = 1;
  localparam int CTRL_RSTBY = 2;
endpackage

// File: rtl/regsync_sync.sv
module regsync_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstn,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstn) begin
    if (!rstn) chain <= '0;
    else       chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/regsync_ctrl.sv
module regsync_ctrl
  import regsync_pkg::*;
#(
  parameter int DW     = 16,
  parameter int STAGES = 2
) (
  input  logic          pclk,
  input  logic          presetn,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [2:0]    paddr,
  input  logic [2:0]    ctrlBits,
  output logic [DW-1:0] prdata,
  output logic          pready,
  output logic          irq,
  output syncStrobe_t   strobe,
  output logic          busy,
  input  logic          ackTog,
  input  logic [DW-1:0] readHold
);
  localparam int PAD = DW - 3;

  logic access, isSyncW, isSyncR, done, readPend;
  logic ackSyncOut, ackSeen;
  logic intEn, intFlag, shEn, shRstby;

  regsync_sync #(.STAGES(STAGES)) u_ackSync (
    .clk(pclk), .rstn(presetn), .d(ackTog), .q(ackSyncOut));

  assign access  = psel & penable;
  assign isSyncW = pwrite & ((paddr == ADDR_CTRL) | (paddr == ADDR_DATA) | (paddr == ADDR_BUF));
  assign isSyncR = !pwrite & (paddr == ADDR_DATA);
  assign done    = busy & (ackSyncOut != ackSeen);

  always_comb begin
    strobe.launch = access & !busy & (isSyncW | (isSyncR & !readPend));
    unique case (paddr)
      ADDR_CTRL: strobe.kind = OP_CTRL;
      ADDR_BUF:  strobe.kind = OP_BUF;
      default:   strobe.kind = pwrite ? OP_DATA : OP_READ;
    endcase
  end

  always_comb begin
    if (!access)      pready = 1'b1;
    else if (isSyncW) pready = !busy;
    else if (isSyncR) pready = readPend & done;
    else              pready = 1'b1;
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      busy <= 1'b0; readPend <= 1'b0; ackSeen <= 1'b0;
      intEn <= 1'b0; intFlag <= 1'b0; shEn <= 1'b0; shRstby <= 1'b0;
    end else begin
      if (strobe.launch) busy <= 1'b1;
      else if (done)     busy <= 1'b0;
      if (done) ackSeen <= ackSyncOut;
      if (strobe.launch && strobe.kind == OP_READ) readPend <= 1'b1;
      else if (done)                               readPend <= 1'b0;
      if (strobe.launch && strobe.kind == OP_CTRL) begin
        shEn    <= ctrlBits[CTRL_SWRST] ? 1'b0 : ctrlBits[CTRL_EN];
        shRstby <= ctrlBits[CTRL_SWRST] ? 1'b0 : ctrlBits[CTRL_RSTBY];
      end
      if (access && pwrite && paddr == ADDR_INTEN) intEn <= ctrlBits[0];
      if (done) intFlag <= 1'b1;
      else if (access && pwrite && paddr == ADDR_FLAG && ctrlBits[0]) intFlag <= 1'b0;
    end
  end

  always_comb begin
    unique case (paddr)
      ADDR_CTRL:   prdata = {{PAD{1'b0}}, shRstby, shEn, 1'b0};
      ADDR_INTEN:  prdata = {{(DW-1){1'b0}}, intEn};
      ADDR_FLAG:   prdata = {{(DW-1){1'b0}}, intFlag};
      ADDR_STATUS: prdata = {{(DW-1){1'b0}}, busy};
      ADDR_DATA:   prdata = readHold;
      default:     prdata = '0;
    endcase
  end

  assign irq = intFlag & intEn;

  p_launch_busy_r3: assert property (@(posedge pclk) disable iff (!presetn)
    strobe.launch |=> busy);
  p_flag_set_r5: assert property (@(posedge pclk) disable iff (!presetn)
    done |=> intFlag);
  p_ack_in_flight_r4: assert property (@(posedge pclk) disable iff (!presetn)
    (ackSyncOut != ackSeen) |-> busy);
endmodule

// File: rtl/regsync_dp.sv
module regsync_dp
  import regsync_pkg::*;
#(
  parameter int DW     = 16,
  parameter int STAGES = 2
) (
  input  logic          pclk,
  input  logic          presetn,
  input  syncStrobe_t   strobe,
  input  logic [DW-1:0] pwdata,
  input  logic          busyIn,
  input  logic          cclk,
  input  logic          cresetn,
  input  logic          coreStandby,
  output logic          ackTog,
  output logic [DW-1:0] readHold,
  output logic [DW-1:0] coreData,
  output logic [DW-1:0] coreDataBuf,
  output logic          coreEnable,
  output logic          outEnable
);
  logic [DW-1:0] holdData;
  opKind_e       holdKind;
  logic          reqTog, reqSyncOut, reqSeen, newReq, runStby, swApply;

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      holdData <= '0; holdKind <= OP_CTRL; reqTog <= 1'b0;
    end else if (strobe.launch) begin
      holdData <= pwdata;
      holdKind <= strobe.kind;
      reqTog   <= ~reqTog;
    end
  end

  regsync_sync #(.STAGES(STAGES)) u_reqSync (
    .clk(cclk), .rstn(cresetn), .d(reqTog), .q(reqSyncOut));

  assign newReq  = reqSyncOut != reqSeen;
  assign swApply = newReq & (holdKind == OP_CTRL) & holdData[CTRL_SWRST];

  always_ff @(posedge cclk or negedge cresetn) begin
    if (!cresetn) begin
      reqSeen <= 1'b0; ackTog <= 1'b0; readHold <= '0;
      coreData <= '0; coreDataBuf <= '0; coreEnable <= 1'b0; runStby <= 1'b0;
    end else if (newReq) begin
      reqSeen <= reqSyncOut;
      ackTog  <= ~ackTog;
      unique case (holdKind)
        OP_CTRL: begin
          if (holdData[CTRL_SWRST]) begin
            coreData <= '0; coreDataBuf <= '0; readHold <= '0;
            runStby  <= 1'b0; coreEnable <= 1'b0;
          end else begin
            coreEnable <= holdData[CTRL_EN];
            runStby    <= holdData[CTRL_RSTBY];
          end
        end
        OP_DATA: coreData    <= holdData;
        OP_BUF:  coreDataBuf <= holdData;
        default: readHold    <= coreData;
      endcase
    end
  end

  assign outEnable = coreEnable & (!coreStandby | runStby);

  p_hold_stable_r1: assert property (@(posedge pclk) disable iff (!presetn)
    ($past(busyIn) && busyIn) |-> $stable(holdData));
  p_swrst_clears_r9: assert property (@(posedge cclk) disable iff (!cresetn)
    swApply |=> (coreData == '0 && coreDataBuf == '0 && !coreEnable));
endmodule

// File: rtl/regsync_top.sv
module regsync_top
  import regsync_pkg::*;
#(
  parameter int DW     = 16,
  parameter int STAGES = 2
) (
  input  logic          pclk,
  input  logic          presetn,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [2:0]    paddr,
  input  logic [DW-1:0] pwdata,
  output logic [DW-1:0] prdata,
  output logic          pready,
  output logic          irq,
  input  logic          cclk,
  input  logic          cresetn,
  input  logic          coreStandby,
  output logic [DW-1:0] coreData,
  output logic [DW-1:0] coreDataBuf,
  output logic          coreEnable,
  output logic          outEnable
);
  syncStrobe_t   strobe;
  logic          busy, ackTog;
  logic [DW-1:0] readHold;

  regsync_ctrl #(.DW(DW), .STAGES(STAGES)) u_ctrl (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .ctrlBits(pwdata[2:0]),
    .prdata(prdata), .pready(pready), .irq(irq), .strobe(strobe),
    .busy(busy), .ackTog(ackTog), .readHold(readHold));

  regsync_dp #(.DW(DW), .STAGES(STAGES)) u_dp (
    .pclk(pclk), .presetn(presetn), .strobe(strobe), .pwdata(pwdata),
    .busyIn(busy), .cclk(cclk), .cresetn(cresetn), .coreStandby(coreStandby),
    .ackTog(ackTog), .readHold(readHold), .coreData(coreData),
    .coreDataBuf(coreDataBuf), .coreEnable(coreEnable), .outEnable(outEnable));
endmodule

// File: tb/regsync_top_bench.sv
module regsync_top_bench;
  localparam int DW = 16;

  logic pclk = 1'b0, cclk = 1'b0;
  logic presetn = 1'b0, cresetn = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0, coreStandby = 1'b0;
  logic [2:0] paddr = '0;
  logic [DW-1:0] pwdata = '0;
  logic [DW-1:0] prdata, coreData, coreDataBuf;
  logic pready, irq, coreEnable, outEnable;
  int total = 0, bad = 0;

  always #2.5 pclk = ~pclk;
  always #3.5 cclk = ~cclk;

  regsync_top #(.DW(DW)) u_regsync_top (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .irq(irq), .cclk(cclk), .cresetn(cresetn),
    .coreStandby(coreStandby), .coreData(coreData), .coreDataBuf(coreDataBuf),
    .coreEnable(coreEnable), .outEnable(outEnable));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apb(input logic wr, input logic [2:0] a, input logic [DW-1:0] d,
                     output logic [DW-1:0] rd, output int waits);
    waits = 0;
    @(negedge pclk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
    @(negedge pclk);
    penable = 1'b1;
    #0.5;
    while (!pready) begin
      @(negedge pclk); #0.5;
      waits++;
    end
    rd = prdata;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic settle();
    repeat (40) @(negedge pclk);
  endtask

  task automatic testReset();
    logic [DW-1:0] rd; int w;
    apb(1'b0, 3'd3, '0, rd, w); check("R10 busy", rd, 0);
    apb(1'b0, 3'd2, '0, rd, w); check("R10 flag", rd, 0);
    apb(1'b0, 3'd1, '0, rd, w); check("R10 inten", rd, 0);
    check("R10 coreData", coreData, 0);
    check("R10 coreDataBuf", coreDataBuf, 0);
    check("R10 outEnable", outEnable, 0);
    check("R10 irq", irq, 0);
  endtask

  task automatic testDataWrite();
    logic [DW-1:0] rd; int w;
    apb(1'b1, 3'd4, 16'h5A3C, rd, w); check("R1 no wait when idle", w, 0);
    apb(1'b0, 3'd3, '0, rd, w);
    check("R3 busy high", rd, 1);
    check("R7 status no wait while busy", w, 0);
    check("R1 not yet applied", coreData, 0);
    settle();
    check("R1 coreData", coreData, 16'h5A3C);
    apb(1'b0, 3'd3, '0, rd, w); check("R3 busy low", rd, 0);
    apb(1'b0, 3'd2, '0, rd, w); check("R5 flag set", rd, 1);
    check("R6 irq masked", irq, 0);
  endtask

  task automatic testIrq();
    logic [DW-1:0] rd; int w;
    apb(1'b1, 3'd1, 16'h1, rd, w); check("R7 inten no wait", w, 0);
    #1 check("R6 irq on", irq, 1);
    apb(1'b1, 3'd2, 16'h1, rd, w); check("R7 flag no wait", w, 0);
    #1 check("R6 irq off after clear", irq, 0);
    apb(1'b0, 3'd2, '0, rd, w); check("R5 flag cleared", rd, 0);
  endtask

  task automatic testCollision();
    logic [DW-1:0] rd; int w;
    apb(1'b1, 3'd5, 16'hBEEF, rd, w);
    apb(1'b1, 3'd4, 16'h1234, rd, w);
    check("R4 wait states", (w > 0) ? 1 : 0, 1);
    apb(1'b1, 3'd2, 16'h1, rd, w); check("R7 flag clear while busy no wait", w, 0);
    settle();
    check("R4 first kept", coreDataBuf, 16'hBEEF);
    check("R4 second applied", coreData, 16'h1234);
  endtask

  task automatic testRead();
    logic [DW-1:0] rd; int w;
    apb(1'b0, 3'd4, '0, rd, w);
    check("R2 stalled", (w > 0) ? 1 : 0, 1);
    check("R2 value", rd, 16'h1234);
    settle();
  endtask

  task automatic testStandby();
    logic [DW-1:0] rd; int w;
    apb(1'b1, 3'd0, 16'h2, rd, w); settle();
    check("R8 enable", coreEnable, 1);
    check("R8 outEnable", outEnable, 1);
    coreStandby = 1'b1; #1;
    check("R8 standby gates", outEnable, 0);
    apb(1'b1, 3'd0, 16'h6, rd, w); settle();
    check("R8 run in standby", outEnable, 1);
    apb(1'b0, 3'd0, '0, rd, w); check("R8 ctrl readback", rd, 16'h6);
    coreStandby = 1'b0;
  endtask

  task automatic testSwReset();
    logic [DW-1:0] rd; int w;
    apb(1'b1, 3'd0, 16'h1, rd, w);
    apb(1'b0, 3'd3, '0, rd, w); check("R9 busy during reset", rd, 1);
    settle();
    check("R9 coreData", coreData, 0);
    check("R9 coreDataBuf", coreDataBuf, 0);
    check("R9 enable", coreEnable, 0);
    check("R9 outEnable", outEnable, 0);
    apb(1'b0, 3'd0, '0, rd, w); check("R9 ctrl reads 0", rd, 0);
    apb(1'b0, 3'd3, '0, rd, w); check("R9 busy cleared", rd, 0);
  endtask

  initial begin
    repeat (5) @(negedge pclk);
    presetn = 1'b1; cresetn = 1'b1;
    repeat (3) @(negedge pclk);
    testReset();
    testDataWrite();
    testIrq();
    testCollision();
    testRead();
    testStandby();
    testSwReset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge pclk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule